// File: doc/BRIEF.md
# Twin-Bank Bit-Reversed Address Sequencer

This block produces the address stream for an FFT working store that is split into two banks of N/2 words each. A load sequence takes a block of N samples that arrives in natural order. Samples in the lower half of the block go to bank A and samples in the upper half go to bank B. Inside its bank, each sample lands at the bit-reversed value of its offset within the half. An unload sequence reads the results out in bit-reversed form. It reads every word of bank A first and then every word of bank B, with the offset inside each bank again bit-reversed. The data path sits outside this block.

The transform size is given as log2(N) and is taken when a start strobe is accepted. Sizes from 64 to 16384 points are supported. The reversal is always done over log2(N)-1 bits, so a small transform uses only the low end of each bank. One sequence emits one address per clock for N clocks without a gap. Its final address is marked by a single-cycle flag.

Top module: `split_bitrev_agen`

## Requirements
- R1: While reset is held and after its release with no strobe, `valid_o` and `last_o` are 0.
- R2: A strobe accepted while idle is followed on the next cycle by `valid_o`=1 for exactly N consecutive cycles, with sequence index j=0 in the first of them, then `valid_o`=0.
- R3: For index j, `bank_o` is 0 (bank A) when j < N/2 and 1 (bank B) otherwise.
- R4: `addr_o` equals the bit reversal of (j mod N/2) over log2(N)-1 bits; `addr_o` bits at or above position log2(N)-1 are 0.
- R5: A load sequence drives `load_o`=1 throughout. An unload sequence drives `load_o`=0 throughout and follows the same bank and address order as R3/R4, so it reads bank A entirely and then bank B.
- R6: `last_o` is 1 only in the cycle carrying j=N-1 and is 0 in every other cycle.
- R7: `log2n_i` values below 6 are used as 6, values above 14 are used as 14, and values from 6 to 14 are used as given.
- R8: The size is captured with the accepted strobe. Changes on `log2n_i` during a sequence have no effect on that sequence.
- R9: Start strobes that arrive while `valid_o`=1, including the cycle of `last_o`, are ignored. The running sequence neither restarts nor lengthens.
- R10: When `load_start_i` and `unload_start_i` are both 1 in an idle cycle, a load sequence starts.
- R11: Within one sequence, every address 0..N/2-1 of each bank appears exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_start_i | input | 1 | Starts a load (write) sequence when idle |
| unload_start_i | input | 1 | Starts an unload (read) sequence when idle |
| log2n_i | input | 4 | log2 of the transform size, clamped to 6..14 |
| valid_o | output | 1 | Address outputs are valid this cycle |
| load_o | output | 1 | 1 for a load sequence, 0 for an unload sequence |
| bank_o | output | 1 | 0 selects bank A, 1 selects bank B |
| addr_o | output | 13 | Word address inside the selected bank |
| last_o | output | 1 | Marks the final address of the sequence |

## Verification
All outputs come straight from registers. The first address therefore appears one clock after the strobe edge, and each following address comes one clock later. `valid_o` falls on the clock after the cycle that carries `last_o`. The bench drives its inputs on falling edges. It then checks a complete expected word (valid, direction, bank, address, last) on each falling edge that follows a rising edge, so the first check falls on the edge right after the strobe is taken. During sequences it toggles the size input and issues stray strobes. It checks on the falling edge after the final address that the sequence has ended, and it checks per sequence that each bank's addresses were all visited exactly once.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned LG_MIN_D = 6;
  localparam int unsigned LG_MAX_D = 14;
  localparam int unsigned LG_W_D   = 4;

  typedef enum logic {OP_UNLOAD = 1'b0, OP_LOAD = 1'b1} op_e;
endpackage

// File: rtl/agen_size_clamp.sv
module agen_size_clamp #(
  parameter int unsigned LG_W   = 4,
  parameter int unsigned LG_MIN = 6,
  parameter int unsigned LG_MAX = 14
) (
  input  logic [LG_W-1:0] lg_i,
  output logic [LG_W-1:0] lg_o
);
  localparam logic [LG_W-1:0] LO = LG_W'(LG_MIN);
  localparam logic [LG_W-1:0] HI = LG_W'(LG_MAX);

  always_comb begin
    if (lg_i < LO)      lg_o = LO;
    else if (lg_i > HI) lg_o = HI;
    else                lg_o = lg_i;
  end
endmodule

// File: rtl/agen_seq_ctrl.sv
module agen_seq_ctrl
  import agen_pkg::*;
#(
  parameter int unsigned LG_W = 4,
  parameter int unsigned CW   = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_start_i,
  input  logic            unload_start_i,
  input  logic [LG_W-1:0] lg_i,
  output logic            active_o,
  output op_e             op_o,
  output logic [LG_W-1:0] lg_o,
  output logic [CW-1:0]   cnt_o,
  output logic            last_o
);
  logic            active_q;
  op_e             op_q;
  logic [LG_W-1:0] lg_q;
  logic [CW-1:0]   cnt_q;
  logic [CW:0]     span;
  logic            end_hit;

  assign span    = (CW+1)'(1) << lg_q;
  assign end_hit = ({1'b0, cnt_q} == (span - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      op_q     <= OP_UNLOAD;
      lg_q     <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (load_start_i || unload_start_i) begin
        active_q <= 1'b1;
        op_q     <= load_start_i ? OP_LOAD : OP_UNLOAD;  // load wins a tie
        lg_q     <= lg_i;
        cnt_q    <= '0;
      end
    end else if (end_hit) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign op_o     = op_q;
  assign lg_o     = lg_q;
  assign cnt_o    = cnt_q;
  assign last_o   = active_q && end_hit;
endmodule

// File: rtl/agen_bitrev.sv
module agen_bitrev #(
  parameter int unsigned LG_W   = 4,
  parameter int unsigned LG_MIN = 6,
  parameter int unsigned LG_MAX = 14,
  localparam int unsigned CW    = LG_MAX,
  localparam int unsigned AW    = LG_MAX - 1,
  localparam int unsigned NV    = LG_MAX - LG_MIN + 1
) (
  input  logic [CW-1:0]   cnt_i,
  input  logic [LG_W-1:0] lg_i,
  output logic            bank_o,
  output logic [AW-1:0]   addr_o
);
  logic [AW-1:0]   cand [NV];
  logic [LG_W-1:0] sel;

  // one reversal network per supported size; upper bits tied low
  for (genvar g = 0; g < NV; g++) begin : g_size
    for (genvar b = 0; b < AW; b++) begin : g_bit
      if (b < LG_MIN + g - 1) begin : g_rev
        assign cand[g][b] = cnt_i[LG_MIN + g - 2 - b];
      end else begin : g_zero
        assign cand[g][b] = 1'b0;
      end
    end
  end

  assign sel    = lg_i - LG_W'(LG_MIN);
  assign addr_o = cand[sel];
  assign bank_o = cnt_i[lg_i - LG_W'(1)];
endmodule

// File: rtl/split_bitrev_agen.sv
module split_bitrev_agen
  import agen_pkg::*;
#(
  parameter int unsigned LG_W   = LG_W_D,
  parameter int unsigned LG_MIN = LG_MIN_D,
  parameter int unsigned LG_MAX = LG_MAX_D,
  localparam int unsigned CW    = LG_MAX,
  localparam int unsigned AW    = LG_MAX - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_start_i,
  input  logic            unload_start_i,
  input  logic [LG_W-1:0] log2n_i,
  output logic            valid_o,
  output logic            load_o,
  output logic            bank_o,
  output logic [AW-1:0]   addr_o,
  output logic            last_o
);
  logic [LG_W-1:0] lg_clamped;
  logic [LG_W-1:0] lg_run;
  logic [CW-1:0]   cnt;
  op_e             op;

  agen_size_clamp #(.LG_W(LG_W), .LG_MIN(LG_MIN), .LG_MAX(LG_MAX)) u_clamp (
    .lg_i (log2n_i),
    .lg_o (lg_clamped)
  );

  agen_seq_ctrl #(.LG_W(LG_W), .CW(CW)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_start_i   (load_start_i),
    .unload_start_i (unload_start_i),
    .lg_i           (lg_clamped),
    .active_o       (valid_o),
    .op_o           (op),
    .lg_o           (lg_run),
    .cnt_o          (cnt),
    .last_o         (last_o)
  );

  agen_bitrev #(.LG_W(LG_W), .LG_MIN(LG_MIN), .LG_MAX(LG_MAX)) u_rev (
    .cnt_i  (cnt),
    .lg_i   (lg_run),
    .bank_o (bank_o),
    .addr_o (addr_o)
  );

  assign load_o = (op == OP_LOAD);
endmodule

// File: rtl/split_bitrev_agen_chk.sv
module split_bitrev_agen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_o,
  input logic load_o,
  input logic bank_o,
  input logic last_o
);
  p_last_in_seq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_no_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);

  p_end_after_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);

  p_dir_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> $stable(load_o));

  p_bank_b_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bank_o && !last_o) |=> bank_o);

  p_starts_in_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> !bank_o);
endmodule

bind split_bitrev_agen split_bitrev_agen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .load_o  (load_o),
  .bank_o  (bank_o),
  .last_o  (last_o)
);

// File: tb/split_bitrev_agen_bench.sv
module split_bitrev_agen_bench;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_start = 1'b0;
  logic          unload_start = 1'b0;
  logic [3:0]    log2n = 4'd6;
  logic          valid, load_dir, bank, last;
  logic [AW-1:0] addr;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [8191:0] seen_a, seen_b;

  always #5 clk = ~clk;

  split_bitrev_agen u_split_bitrev_agen (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .load_start_i   (load_start),
    .unload_start_i (unload_start),
    .log2n_i        (log2n),
    .valid_o        (valid),
    .load_o         (load_dir),
    .bank_o         (bank),
    .addr_o         (addr),
    .last_o         (last)
  );

  function automatic logic [AW-1:0] rev_bits(input int idx, input int w);
    logic [AW-1:0] r = '0;
    for (int b = 0; b < w; b++) r[b] = idx[w-1-b];
    return r;
  endfunction

  function automatic int clamp_lg(input int v);
    return (v < 6) ? 6 : ((v > 14) ? 14 : v);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // word = {valid, load, bank, last, addr}
  task automatic run_seq(input bit do_load, input bit do_unload, input int lg_in, input bit noisy);
    int lg, n, half;
    bit exp_load;
    logic [31:0] act, exp;
    lg = clamp_lg(lg_in);
    n = 1 << lg;
    half = n / 2;
    exp_load = do_load;
    seen_a = '0;
    seen_b = '0;
    @(negedge clk);
    load_start = do_load;
    unload_start = do_unload;
    log2n = 4'(lg_in);
    @(negedge clk);
    load_start = 1'b0;
    unload_start = 1'b0;
    for (int j = 0; j < n; j++) begin
      act = {15'd0, valid, load_dir, bank, last, addr};
      exp = {15'd0, 1'b1, exp_load, (j >= half), (j == n-1), rev_bits(j % half, lg-1)};
      chk(act == exp, "R2 R3 R4 R5 R6 R7 R8 R10", act, exp);
      if (bank) seen_b[addr] = 1'b1; else seen_a[addr] = 1'b1;
      if (noisy) begin
        log2n = 4'($urandom_range(0, 15));
        load_start = 1'($urandom_range(0, 1));
        unload_start = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
    end
    load_start = 1'b0;
    unload_start = 1'b0;
    act = {30'd0, valid, last};
    chk(act == 32'd0, "R9 end of sequence", act, 32'd0);
    chk(($countones(seen_a) == half) && ($countones(seen_b) == half), "R11 coverage",
        32'($countones(seen_a) + $countones(seen_b)), 32'(n));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk({valid, last} == 2'b00, "R1 in reset", {30'd0, valid, last}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({valid, last} == 2'b00, "R1 after reset", {30'd0, valid, last}, 32'd0);
    // all sizes, both directions
    for (int lg = 6; lg <= 14; lg++) begin
      run_seq(1'b1, 1'b0, lg, lg < 10);
      run_seq(1'b0, 1'b1, lg, lg >= 10);
    end
    // clamp corners R7
    run_seq(1'b1, 1'b0, 0, 1'b1);
    run_seq(1'b0, 1'b1, 5, 1'b0);
    run_seq(1'b0, 1'b1, 15, 1'b1);
    // tie R10
    run_seq(1'b1, 1'b1, 7, 1'b1);
    // random mix, small sizes
    for (int k = 0; k < 20; k++) begin
      int sel;
      sel = int'($urandom_range(0, 2));
      run_seq(sel != 1, sel != 0, int'($urandom_range(0, 10)), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule